// File: doc/BRIEF.md
# Two-Wire Three-State Serial Transmitter

This block sends 32-bit words over a pair of lines, P and N, that carry three line states. When both lines are high, the bus is at rest. Each bit opens with both lines pulled low. One line then rises to mark the bit value: N rises for a zero and P rises for a one. Words are delivered through a valid/ready input and shifted out least significant bit first. A last-word flag closes a frame. Inside a frame the bits follow one another with no rest state between them, including across word boundaries.

Each timed phase lasts `PHASE_CYCLES` system clock cycles. This parameter is meant to be set to the number of cycles in one 125 ns slot. The rest state is held for at least `PHASE_CYCLES+1` cycles before a frame opens and after it closes, so the line has settled before the next transfer.

Top module: `tw_serial_tx`

## Requirements
- R1: While reset is asserted, both lines are high and `in_ready` is low. After reset is released, `in_ready` first rises in the `PHASE_CYCLES`-th cycle.
- R2: The rest state (P=1, N=1) lasts at least `PHASE_CYCLES+1` cycles before every frame and after every frame.
- R3: Every bit starts with P=0 and N=0 for exactly `PHASE_CYCLES` cycles, and the phase that follows has exactly one line high.
- R4: The value phase lasts `PHASE_CYCLES` cycles. A 0 bit drives P=0, N=1 and a 1 bit drives P=1, N=0.
- R5: Each word goes out bit 0 first and bit 31 last. The word 0x000000CA therefore begins with the bits 0,1,0,1,0,0,1,1.
- R6: The words of a frame are sent back to back with no rest state between them. The line returns to rest only after bit 31 of the word that was taken with `in_last`=1.
- R7: `in_ready` is low for the whole of every bit of a word except the value phase of bit 31 of a non-last word. Outside a frame it is high only once the rest state has lasted the minimum time.
- R8: If the next word of a frame is not offered when bit 31 of a non-last word ends, the value phase of that bit is held with `in_ready` high. The frame resumes with a low phase once the word is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | A word is offered |
| in_data | input | WORD_W | Word to send, bit 0 first |
| in_last | input | 1 | Offered word closes the frame |
| in_ready | output | 1 | Word is taken on this cycle if `in_valid` is high |
| line_p | output | 1 | P line |
| line_n | output | 1 | N line |

## Verification
The bench decodes the lines into phase lengths and bit values and compares each rebuilt word with the word it offered. The cases it aims at are these:
- The 0xCA byte order, which a design that sends the high bit first would reverse.
- Word boundaries within multi-word frames, where a design that slips in a rest state or misplaces the handoff would leave an idle run or a short phase.
- The reset-to-ready delay, which would be off by a cycle if the rest-time counter were miscounted.
- A late next word, where a design that does not stretch the final value phase would drop a bit or return the line to rest in the middle of a frame.

// File: rtl/tw_serial_tx.sv
module tw_serial_tx #(
  parameter int PHASE_CYCLES = 4,
  parameter int WORD_W       = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_data,
  input  logic              in_last,
  output logic              in_ready,
  output logic              line_p,
  output logic              line_n
);
  localparam int CW = $clog2(PHASE_CYCLES + 1) + 1;
  localparam int BW = $clog2(WORD_W);
  localparam logic [CW-1:0] PH_END   = CW'(PHASE_CYCLES - 1);
  localparam logic [CW-1:0] IDLE_END = CW'(PHASE_CYCLES);
  localparam logic [BW-1:0] LAST_BIT = BW'(WORD_W - 1);

  typedef enum logic [1:0] {S_IDLE, S_LOW, S_HIGH} st_t;

  st_t              st;
  logic [CW-1:0]    cnt;
  logic [BW-1:0]    bidx;
  logic [WORD_W-1:0] sh;
  logic             last_q;

  wire phase_done = (cnt == PH_END);
  wire word_end   = (st == S_HIGH) && phase_done && (bidx == LAST_BIT);
  assign in_ready = ((st == S_IDLE) && (cnt == IDLE_END)) || (word_end && !last_q);
  wire take       = in_valid && in_ready;

  assign line_p = (st == S_IDLE) || ((st == S_HIGH) &&  sh[0]);
  assign line_n = (st == S_IDLE) || ((st == S_HIGH) && !sh[0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      cnt    <= '0;
      bidx   <= '0;
      sh     <= '0;
      last_q <= 1'b0;
    end else begin
      case (st)
        S_IDLE: begin
          if (take) begin
            sh     <= in_data;
            last_q <= in_last;
            bidx   <= '0;
            st     <= S_LOW;
            cnt    <= '0;
          end else if (cnt != IDLE_END) begin
            cnt <= cnt + 1'b1;
          end
        end
        S_LOW: begin
          if (phase_done) begin
            st  <= S_HIGH;
            cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_HIGH: begin
          if (!phase_done) begin
            cnt <= cnt + 1'b1;
          end else if (bidx != LAST_BIT) begin
            bidx <= bidx + 1'b1;
            sh   <= sh >> 1;
            st   <= S_LOW;
            cnt  <= '0;
          end else if (last_q) begin
            st  <= S_IDLE;
            cnt <= '0;
          end else if (take) begin
            sh     <= in_data;
            last_q <= in_last;
            bidx   <= '0;
            st     <= S_LOW;
            cnt    <= '0;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_IDLE_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_LOW && $past(st) == S_IDLE) |-> $past(cnt) == IDLE_END); // R2
  AST_LOW_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_HIGH && $past(st) == S_LOW) |-> $past(cnt) == PH_END); // R3
  AST_HIGH_SPLIT: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_HIGH) |-> (line_p != line_n)); // R4
  AST_END_ON_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && $past(st) == S_HIGH) |-> ($past(last_q) && $past(bidx) == LAST_BIT)); // R6
  AST_NO_READY_MIDWORD: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && st != S_IDLE) |-> (st == S_HIGH && bidx == LAST_BIT && !last_q)); // R7
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (word_end && !last_q && !in_valid) |=> (st == S_HIGH && $stable(line_p) && $stable(line_n))); // R8
endmodule

// File: tb/tw_serial_tx_test.sv
module tw_serial_tx_test;
  localparam int PC = 3;

  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0, in_last = 1'b0;
  logic [31:0] in_data = '0;
  wire in_ready, line_p, line_n;

  tw_serial_tx #(.PHASE_CYCLES(PC), .WORD_W(32)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_last(in_last), .in_ready(in_ready), .line_p(line_p), .line_n(line_n));

  always #10 clk = ~clk;

  int errors = 0, checks = 0;
  logic [31:0] exp_w [0:127];
  int n_sent = 0, n_rcv = 0;
  logic stretch_ok = 1'b0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  logic [1:0] prev = 2'b11;
  int run = 100;
  logic [31:0] rx = '0;
  int bits = 0;
  int midword_bad = 0;
  logic [7:0] first8 = '0;
  int total_bits = 0;

  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [1:0] cur;
      cur = {line_p, line_n};
      if (cur != 2'b11 && bits != 31 && in_ready) midword_bad++;
      if (cur == prev) run++;
      else begin
        case (prev)
          2'b11: chk(run >= PC + 1, "R2", "rest length before frame", run, PC + 1);
          2'b00: begin
            chk(run == PC, "R3", "low phase length", run, PC);
            chk(cur == 2'b10 || cur == 2'b01, "R3", "state after low", cur, 2'b10);
          end
          default: begin
            if (stretch_ok) chk(run >= PC, "R8", "stretched value phase", run, PC);
            else chk(run == PC, "R4", "value phase length", run, PC);
            rx = {prev[1], rx[31:1]};
            bits++;
            total_bits++;
            if (total_bits <= 8) first8 = {first8[6:0], prev[1]};
            if (total_bits == 8) chk(first8 == 8'h53, "R5", "0xCA bit order", first8, 8'h53);
            if (bits == 32) begin
              chk(rx == exp_w[n_rcv], "R5", "decoded word", rx, exp_w[n_rcv]);
              chk(midword_bad == 0, "R7", "ready during word", midword_bad, 0);
              midword_bad = 0;
              n_rcv++;
              bits = 0;
            end
            if (cur == 2'b11) chk(bits == 0, "R6", "rest only at word end", bits, 0);
          end
        endcase
        run = 1;
      end
      prev = cur;
    end
  end

  task automatic send_word(input logic [31:0] d, input bit last, input int stall);
    if (stall > 0) begin
      while (!in_ready) @(negedge clk);
      for (int s = 0; s < stall; s++) begin
        logic [1:0] held;
        held = {line_p, line_n};
        @(negedge clk);
        chk(in_ready && {line_p, line_n} == held, "R8", "hold while waiting",
            {in_ready, line_p, line_n}, {1'b1, held});
      end
    end
    exp_w[n_sent] = d;
    n_sent++;
    in_valid = 1'b1; in_data = d; in_last = last;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
  endtask

  task automatic frame(input int n, input logic [31:0] seed, input int stall);
    for (int w = 0; w < n; w++)
      send_word(seed * 32'h9E3779B9 + 32'(w) * 32'h01234567 ^ (seed << w), w == n - 1, w == 0 ? 0 : stall);
    repeat (64 * PC + 3 * PC + 6) @(negedge clk);
    chk(line_p && line_n, "R6", "rest after frame", {line_p, line_n}, 2'b11);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(line_p && line_n && !in_ready, "R1", "reset state", {line_p, line_n, in_ready}, 3'b110);
    rst_n = 1'b1;
    for (int k = 1; k <= PC; k++) begin
      @(negedge clk);
      chk(in_ready == (k == PC), "R1", "ready after reset", in_ready, k == PC);
    end
    // R5 first word 0xCA
    exp_w[n_sent] = 32'h000000CA; n_sent++;
    in_valid = 1'b1; in_data = 32'h000000CA; in_last = 1'b1;
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
    repeat (64 * PC + 3 * PC + 6) @(negedge clk);
    // R6 single word edge values
    send_word(32'hFFFFFFFF, 1'b1, 0);
    repeat (64 * PC + 3 * PC + 6) @(negedge clk);
    send_word(32'h00000000, 1'b0, 0);
    send_word(32'h80000001, 1'b1, 0);
    repeat (64 * PC + 3 * PC + 6) @(negedge clk);
    for (int n = 1; n <= 4; n++)
      for (int s = 1; s <= 3; s++) frame(n, 32'(n * 7 + s), 0);
    stretch_ok = 1'b1;
    frame(3, 32'hA5A5A5A5, 5);
    frame(2, 32'h0F0F0F0F, 1);
    stretch_ok = 1'b0;
    chk(n_rcv == n_sent, "R6", "word count", n_rcv, n_sent);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule